// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches page mappings so that a 32-bit virtual address can be turned into a physical address within the same cycle. Pages are 4 KB. The low twelve address bits pass through unchanged. The upper twenty bits form the virtual page number, which is compared against every stored entry at once. Any page may occupy any slot. Each slot holds a page-number tag, a physical frame number, read/write/execute permission bits, a valid bit, a dirty bit and a recently-used bit. A lookup port takes an address and an access kind. It returns hit, miss and protection-fault flags together with the translated address.

After a miss, an external walker installs the mapping through the fill port. The block chooses the slot to use. It takes the lowest-index empty slot if one exists. Otherwise it takes the lowest-index slot that has not been used recently. One cycle after the fill, the block reports the frame number and dirty state of any valid mapping it displaced, so that the requester can write that page back if needed. A flush input drops every mapping in one cycle, for use on a switch of address space.

Top module: `va_xlat_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the stored frame number in bits 31:12, and `lk_vaddr[11:0]` in bits 11:0, in the same cycle as the lookup.
- R2: A lookup hits only if a valid entry's page number equals `lk_vaddr[31:12]`. With `lk_valid` high and no such entry, `lk_miss` is 1 and `lk_hit` is 0. Whenever there is no hit, `lk_paddr` is 0. With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all 0.
- R3: A mapping installed by a fill that is not flushed hits on the next lookup of its page, whichever slot it lands in.
- R4: `fl_perm` bit 0 allows read, bit 1 allows write and bit 2 allows execute. `lk_kind` is 00 for read, 01 for write and 10 for execute; 11 is never permitted. `lk_fault` is 1 exactly when a hit's access kind is not permitted, and `lk_hit` stays 1 in that case.
- R5: A write hit that does not fault sets the entry's dirty bit. A write that faults leaves the dirty bit unchanged. A fill clears the dirty bit of the slot it writes.
- R6: The recently-used bit of a slot is set by a fill of that slot and by a lookup hit on it that does not fault. If this would leave every bit set, only the bits set in that cycle are kept.
- R7: A fill of a page not already present goes to the lowest-index invalid slot. If no slot is invalid, it goes to the lowest-index slot whose recently-used bit is clear.
- R8: In the cycle after a fill that displaces a valid mapping, `ev_valid` is 1 and `ev_pfn` and `ev_dirty` give that mapping's frame number and dirty bit. After any other cycle, `ev_valid` is 0.
- R9: A fill whose page number is already present overwrites that slot with the new frame and permissions, and reports no eviction.
- R10: A flush invalidates every entry and clears every recently-used bit in one cycle. A fill in the same cycle as a flush is discarded.
- R11: After reset, every entry is invalid, every lookup misses and `ev_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 none |
| lk_hit | output | 1 | A valid entry matches the page |
| lk_miss | output | 1 | Lookup requested and no entry matches |
| lk_fault | output | 1 | Hit whose access kind is not permitted |
| lk_paddr | output | 32 | Translated physical address, 0 without a hit |
| fl_valid | input | 1 | Install a mapping |
| fl_vpn | input | 20 | Virtual page number to install |
| fl_pfn | input | 20 | Physical frame number to install |
| fl_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| ev_valid | output | 1 | A valid mapping was displaced by the previous cycle's fill |
| ev_pfn | output | 20 | Frame number of the displaced mapping |
| ev_dirty | output | 1 | Dirty bit of the displaced mapping |

## Verification
The assertions assume that reset is held across the first clock edges and that `rst_n` is the only source of reset. They also assume that the walker never requests a fill during the internal reset-release window. The property linking a fill to the next lookup relies on the fill port always presenting a complete mapping whenever `fl_valid` is high.

All stimulus is applied on the falling clock edge. Fills and lookups are issued in separate cycles, except where the overlap itself is the case under test. Recently-used bits are first cleared by a flush so that every victim slot in the replacement sequence can be predicted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  localparam int PERM_W_BITS = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  function automatic logic access_ok(input logic [PERM_W_BITS-1:0] perm,
                                     input acc_kind_e kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = perm[PERM_RD];
      ACC_WRITE: ok = perm[PERM_WR];
      ACC_EXEC:  ok = perm[PERM_EX];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 8,
  parameter int KEY_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][KEY_W-1:0] tags,
  input  logic [KEY_W-1:0]        key,
  output logic [N-1:0]            hit_vec,
  output logic                    hit_any,
  output logic [IDX_W-1:0]        hit_idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     used,
  output logic [IDX_W-1:0] pick
);

  logic found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && !valid[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!found && !used[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          fill_en,
  input  logic [IDX_W-1:0]              fill_idx,
  input  logic [VPN_W-1:0]              fill_vpn,
  input  logic [PFN_W-1:0]              fill_pfn,
  input  logic [PERM_W_BITS-1:0]        fill_perm,
  input  logic                          use_en,
  input  logic [IDX_W-1:0]              use_idx,
  input  logic                          dirty_en,
  output logic [N-1:0]                  valid_q,
  output logic [N-1:0][VPN_W-1:0]       vpn_q,
  output logic [N-1:0][PFN_W-1:0]       pfn_q,
  output logic [N-1:0][PERM_W_BITS-1:0] perm_q,
  output logic [N-1:0]                  dirty_q,
  output logic [N-1:0]                  used_q
);

  logic [N-1:0]                  valid_d, dirty_d, used_d, set_mask, used_or;
  logic [N-1:0][VPN_W-1:0]       vpn_d;
  logic [N-1:0][PFN_W-1:0]       pfn_d;
  logic [N-1:0][PERM_W_BITS-1:0] perm_d;
  logic                          upd;

  assign upd = flush | fill_en | use_en;

  always_comb begin
    valid_d  = valid_q;
    dirty_d  = dirty_q;
    vpn_d    = vpn_q;
    pfn_d    = pfn_q;
    perm_d   = perm_q;
    set_mask = '0;
    if (use_en) begin
      set_mask[use_idx] = 1'b1;
      if (dirty_en) dirty_d[use_idx] = 1'b1;
    end
    if (fill_en) begin
      valid_d[fill_idx]  = 1'b1;
      vpn_d[fill_idx]    = fill_vpn;
      pfn_d[fill_idx]    = fill_pfn;
      perm_d[fill_idx]   = fill_perm;
      dirty_d[fill_idx]  = 1'b0;
      set_mask[fill_idx] = 1'b1;
    end
    used_or = used_q | set_mask;
    used_d  = (&used_or) ? set_mask : used_or;
    if (flush) begin
      valid_d = '0;
      used_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      used_q  <= '0;
    end else if (upd) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      used_q  <= used_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q  <= vpn_d;
      pfn_q  <= pfn_d;
      perm_q <= perm_d;
    end
  end

endmodule

// File: rtl/va_xlat_tlb.sv
module va_xlat_tlb
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PFN_W = PA_W - PAGE_BITS,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic [1:0]             lk_kind,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_fault,
  output logic [PA_W-1:0]        lk_paddr,
  input  logic                   fl_valid,
  input  logic [VPN_W-1:0]       fl_vpn,
  input  logic [PFN_W-1:0]       fl_pfn,
  input  logic [PERM_W_BITS-1:0] fl_perm,
  output logic                   ev_valid,
  output logic [PFN_W-1:0]       ev_pfn,
  output logic                   ev_dirty
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ENTRIES-1:0]                  valid_q, dirty_q, used_q;
  logic [ENTRIES-1:0][VPN_W-1:0]       vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]       pfn_q;
  logic [ENTRIES-1:0][PERM_W_BITS-1:0] perm_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_hit_vec, fl_hit_vec;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_idx, fl_idx, vic_idx, fill_idx;
  logic               perm_ok, use_en, dirty_en, fill_go, ev_d;
  acc_kind_e          kind;

  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
  assign kind   = acc_kind_e'(lk_kind);

  xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(vpn_q), .key(lk_vpn),
    .hit_vec(lk_hit_vec), .hit_any(lk_any), .hit_idx(lk_idx)
  );

  xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_fl_match (
    .valid(valid_q), .tags(vpn_q), .key(fl_vpn),
    .hit_vec(fl_hit_vec), .hit_any(fl_any), .hit_idx(fl_idx)
  );

  xlat_victim #(.N(ENTRIES)) u_victim (
    .valid(valid_q), .used(used_q), .pick(vic_idx)
  );

  assign perm_ok  = access_ok(perm_q[lk_idx], kind);
  assign lk_hit   = lk_valid && lk_any;
  assign lk_miss  = lk_valid && !lk_any;
  assign lk_fault = lk_hit && !perm_ok;
  assign lk_paddr = lk_hit ? {pfn_q[lk_idx], lk_vaddr[PAGE_BITS-1:0]} : '0;

  assign use_en   = lk_hit && perm_ok;
  assign dirty_en = use_en && (kind == ACC_WRITE);
  assign fill_go  = fl_valid && !flush;
  assign fill_idx = fl_any ? fl_idx : vic_idx;
  assign ev_d     = fill_go && !fl_any && valid_q[vic_idx];

  xlat_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_int_n), .flush(flush),
    .fill_en(fill_go), .fill_idx(fill_idx), .fill_vpn(fl_vpn),
    .fill_pfn(fl_pfn), .fill_perm(fl_perm),
    .use_en(use_en), .use_idx(lk_idx), .dirty_en(dirty_en),
    .valid_q(valid_q), .vpn_q(vpn_q), .pfn_q(pfn_q), .perm_q(perm_q),
    .dirty_q(dirty_q), .used_q(used_q)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ev_valid <= 1'b0;
      ev_pfn   <= '0;
      ev_dirty <= 1'b0;
    end else begin
      ev_valid <= ev_d;
      if (fill_go) begin
        ev_pfn   <= pfn_q[vic_idx];
        ev_dirty <= dirty_q[vic_idx];
      end
    end
  end

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int N         = 8,
  localparam int VPN_W = VA_W - PAGE_BITS
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             flush,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             fl_valid,
  input logic [VPN_W-1:0] fl_vpn,
  input logic             ev_valid,
  input logic [N-1:0]     lk_hit_vec
);

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]); // R1

  AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lk_hit |-> lk_paddr == '0); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lk_valid |-> !lk_hit && !lk_miss && !lk_fault); // R2

  AST_FILL_HITS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fl_valid && !flush) ##1 (lk_valid && lk_vaddr[VA_W-1:PAGE_BITS] == $past(fl_vpn))
    |-> lk_hit); // R3

  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_fault |-> lk_hit); // R4

  AST_EVICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ev_valid |-> $past(fl_valid && !flush)); // R8

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(lk_hit_vec)); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |=> !lk_hit); // R10

endmodule

bind va_xlat_tlb xlat_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .N(ENTRIES)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .flush(flush),
  .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
  .fl_valid(fl_valid), .fl_vpn(fl_vpn), .ev_valid(ev_valid),
  .lk_hit_vec(lk_hit_vec)
);

// File: tb/tb_va_xlat_tlb.sv
module tb_va_xlat_tlb;

  logic        clk, rst_n, flush;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic        fl_valid;
  logic [19:0] fl_vpn, fl_pfn;
  logic [2:0]  fl_perm;
  logic        ev_valid, ev_dirty;
  logic [19:0] ev_pfn;

  int n_chk  = 0;
  int n_fail = 0;

  va_xlat_tlb dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_perm(fl_perm),
    .ev_valid(ev_valid), .ev_pfn(ev_pfn), .ev_dirty(ev_dirty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] kind,
                      output logic hit, output logic miss, output logic fault,
                      output logic [31:0] pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind;
    #1;
    hit = lk_hit; miss = lk_miss; fault = lk_fault; pa = lk_paddr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic [2:0] perm, input logic with_flush,
                      output logic evv, output logic [19:0] evp, output logic evd);
    @(negedge clk);
    fl_valid = 1'b1; fl_vpn = vpn; fl_pfn = pfn; fl_perm = perm; flush = with_flush;
    @(negedge clk);
    evv = ev_valid; evp = ev_pfn; evd = ev_dirty;
    fl_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    logic h, m, f; logic [31:0] p;
    @(negedge clk);
    chk(!lk_hit && !lk_miss && !lk_fault, "R2", "idle flags", {lk_hit, lk_miss, lk_fault}, 0);
    chk(ev_valid == 1'b0, "R11", "ev_valid after reset", ev_valid, 0);
    look(32'h1234_5678, 2'b00, h, m, f, p);
    chk(!h && m, "R11", "lookup after reset misses", {h, m}, 2'b01);
    chk(p == 32'h0, "R2", "paddr on miss", p, 0);
  endtask

  task automatic t_translate();
    logic h, m, f, evv, evd; logic [31:0] p; logic [19:0] evp;
    fill(20'h12345, 20'hABCDE, 3'b011, 1'b0, evv, evp, evd);
    chk(!evv, "R8", "no eviction into empty", evv, 0);
    look(32'h1234_5678, 2'b00, h, m, f, p);
    chk(h && !m && !f, "R3", "filled page hits", {h, m, f}, 3'b100);
    chk(p == 32'hABCD_E678, "R1", "translated address", p, 32'hABCD_E678);
    look(32'h1234_6678, 2'b00, h, m, f, p);
    chk(!h && m && p == 0, "R2", "neighbour page misses", {h, m}, 2'b01);
  endtask

  task automatic t_perm();
    logic h, m, f, evv, evd; logic [31:0] p; logic [19:0] evp;
    fill(20'h00777, 20'h00888, 3'b100, 1'b0, evv, evp, evd);
    look(32'h0077_7010, 2'b00, h, m, f, p);
    chk(h && f, "R4", "read of execute-only faults", {h, f}, 2'b11);
    look(32'h0077_7010, 2'b10, h, m, f, p);
    chk(h && !f, "R4", "execute permitted", {h, f}, 2'b10);
    look(32'h0077_7010, 2'b01, h, m, f, p);
    chk(h && f, "R4", "write to execute-only faults", {h, f}, 2'b11);
    look(32'h1234_5000, 2'b11, h, m, f, p);
    chk(h && f, "R4", "kind 11 faults", {h, f}, 2'b11);
  endtask

  task automatic t_nru_dirty();
    logic h, m, f, evv, evd; logic [31:0] p; logic [19:0] evp;
    do_flush();
    look(32'h1234_5000, 2'b00, h, m, f, p);
    chk(!h && m, "R10", "flush drops mapping", {h, m}, 2'b01);
    for (int i = 0; i < 8; i++) begin
      fill(20'h0A000 + 20'(i), 20'h00100 + 20'(i), (i == 3) ? 3'b001 : 3'b011,
           1'b0, evv, evp, evd);
      chk(!evv, "R7", "invalid slots used first", evv, 0);
    end
    look(32'h0A00_2000, 2'b01, h, m, f, p);
    chk(h && !f, "R5", "permitted write", {h, f}, 2'b10);
    look(32'h0A00_0000, 2'b00, h, m, f, p);
    look(32'h0A00_3000, 2'b01, h, m, f, p);
    chk(h && f, "R5", "write to read-only faults", {h, f}, 2'b11);
    fill(20'h0B000, 20'h00200, 3'b011, 1'b0, evv, evp, evd);
    chk(evv && evp == 20'h00101 && !evd, "R7", "first clear-used slot evicted",
        {evv, evp, evd}, {1'b1, 20'h00101, 1'b0});
    fill(20'h0B001, 20'h00201, 3'b011, 1'b0, evv, evp, evd);
    chk(evv && evp == 20'h00103 && !evd, "R5", "faulted write left page clean",
        {evv, evp, evd}, {1'b1, 20'h00103, 1'b0});
    fill(20'h0B002, 20'h00202, 3'b011, 1'b0, evv, evp, evd);
    fill(20'h0B003, 20'h00203, 3'b011, 1'b0, evv, evp, evd);
    chk(evv && evp == 20'h00105, "R8", "evicted frame", evp, 20'h00105);
    fill(20'h0B004, 20'h00204, 3'b011, 1'b0, evv, evp, evd);
    chk(evv && evp == 20'h00106, "R6", "last clear slot before wrap", evp, 20'h00106);
    fill(20'h0B005, 20'h00205, 3'b011, 1'b0, evv, evp, evd);
    chk(evv && evp == 20'h00100 && !evd, "R6", "used bits reset on saturation",
        {evv, evp, evd}, {1'b1, 20'h00100, 1'b0});
    fill(20'h0B006, 20'h00206, 3'b011, 1'b0, evv, evp, evd);
    chk(evv && evp == 20'h00200, "R7", "victim after wrap", evp, 20'h00200);
    fill(20'h0B007, 20'h00207, 3'b011, 1'b0, evv, evp, evd);
    chk(evv && evp == 20'h00102 && evd, "R5", "dirty page reported",
        {evv, evp, evd}, {1'b1, 20'h00102, 1'b1});
    look(32'h0A00_1000, 2'b00, h, m, f, p);
    chk(!h && m, "R2", "evicted page misses", {h, m}, 2'b01);
  endtask

  task automatic t_refill();
    logic h, m, f, evv, evd; logic [31:0] p; logic [19:0] evp;
    fill(20'h0B003, 20'h003FF, 3'b111, 1'b0, evv, evp, evd);
    chk(!evv, "R9", "refill of present page evicts nothing", evv, 0);
    look(32'h0B00_3ABC, 2'b00, h, m, f, p);
    chk(h && p == 32'h003F_FABC, "R9", "refill updates frame", p, 32'h003F_FABC);
    look(32'h0B00_4000, 2'b00, h, m, f, p);
    chk(h && p == 32'h0020_4000, "R9", "other entries untouched", p, 32'h0020_4000);
  endtask

  task automatic t_flush();
    logic h, m, f, evv, evd; logic [31:0] p; logic [19:0] evp;
    do_flush();
    look(32'h0B00_4000, 2'b00, h, m, f, p);
    chk(!h && m, "R10", "flush invalidates all", {h, m}, 2'b01);
    fill(20'h0C000, 20'h00300, 3'b011, 1'b1, evv, evp, evd);
    chk(!evv, "R10", "fill with flush reports nothing", evv, 0);
    look(32'h0C00_0000, 2'b00, h, m, f, p);
    chk(!h && m, "R10", "fill with flush discarded", {h, m}, 2'b01);
    fill(20'h0D000, 20'h00400, 3'b011, 1'b0, evv, evp, evd);
    chk(!evv, "R7", "fill after flush uses empty slot", evv, 0);
    look(32'h0D00_0123, 2'b00, h, m, f, p);
    chk(h && p == 32'h0040_0123, "R3", "hit after flush refill", p, 32'h0040_0123);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_kind = '0;
    fl_valid = 1'b0; fl_vpn = '0; fl_pfn = '0; fl_perm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_translate();
    t_perm();
    t_nru_dirty();
    t_refill();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule